// File: doc/BRIEF.md
# Clock Supervisor with Stop-Recovery Sequencer

This block watches the bus clock and controls how the core restarts after a low-power stop. A free-running reference clock drives every register in the block. The bus clock reaches the block only as a sampled level on `bus_clk_smp`. When the bus clock stalls or slows while monitoring is armed, the block drives a clock-failure reset for a fixed number of reference cycles.

A small option register holds four control bits: monitor enable, a forced-monitor bit, restart-delay select and interrupt-sense select. The forced-monitor bit can only be set by a write. After that it stays set until system reset, it keeps the monitor armed and it blocks entry into stop. A stop request parks the sequencer. A wake request then starts a short or long restart count, and a one-cycle resume pulse marks the end of that count. The interrupt line is synchronised and presented either as a low level or as a latched falling edge that software acknowledges.

No port streams data, so no port uses a valid/ready handshake and no port applies back-pressure. Every pin is a plain level or a single-cycle pulse that is sampled on the rising edge of `clk`.

Top module: `clksup_top`

## Requirements
- R1: After `rst_n` is released, `opt_rd` reads 0 and `fail_rst`, `resume`, `stop_active` and `irq_req` are all 0.
- R2: A write (`wr_en`=1) stores `wr_data` so that `opt_rd` shows it one cycle later. The bits are: bit 0 monitor enable, bit 1 forced monitor, bit 2 long restart delay, bit 3 falling-edge interrupt sense.
- R3: Once bit 1 is set, a later write of 0 to it leaves it at 1. Only `rst_n` clears it.
- R4: The monitor is armed when bit 0 or bit 1 is set. While it is disarmed, a stalled bus clock never asserts `fail_rst`.
- R5: While the monitor is armed, a clock failure is declared after 16 reference cycles with no detected bus-clock edge. This detection passes through a two-flop synchroniser. For the last transition of `bus_clk_smp`, applied before clock edge k, `fail_rst` is high on cycles k+18 to k+21 (4 cycles) and low before that.
- R6: A bus clock that toggles at least once every reference cycle never asserts `fail_rst`.
- R7: When the block is not stopped and bit 1 is 0, a `stop_req` sampled high sets `stop_active` from the next cycle on. When bit 1 is 1, `stop_req` is ignored and `stop_active` stays 0.
- R8: While stopped, a `wake` sampled on edge E0 raises `resume` for exactly one cycle, starting N cycles after E0. N is 4064 with bit 2 = 1 and 4 with bit 2 = 0. `stop_active` falls in the same cycle that `resume` rises.
- R9: With bit 3 = 0, `irq_req` follows the inverted `irq_n` with a delay of two cycles.
- R10: With bit 3 = 1, a falling edge on `irq_n` sets `irq_req` three cycles later. `irq_req` then stays set while `irq_n` is held low or high, until an `irq_ack` pulse clears it one cycle later.
- R11: While the block is stopped with bits 0 and 1 both clear, a halted bus clock produces no `fail_rst`, and wake-up still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| wr_en | input | 1 | Option register write strobe |
| wr_data | input | 4 | Option register write value |
| opt_rd | output | 4 | Option register contents |
| stop_req | input | 1 | Request to enter stop |
| wake | input | 1 | Wake request while stopped |
| bus_clk_smp | input | 1 | Sampled level of the bus clock |
| irq_n | input | 1 | External interrupt line, active low |
| irq_ack | input | 1 | Clears the latched edge interrupt |
| fail_rst | output | 1 | Clock-failure reset request |
| resume | output | 1 | One-cycle pulse ending a stop |
| stop_active | output | 1 | Core is stopped or restarting |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
Each result has a fixed latency. A register write shows on `opt_rd` one cycle after the write strobe is sampled. The stop state shows one cycle after the request. Interrupt level sense takes two cycles and edge sense takes three. The clock-failure reset covers cycles 18 to 21 after the last bus-clock transition. `resume` arrives exactly N cycles after wake, with N set by the delay bit. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from each stimulus and compares the outputs on every cycle of the window, both inside and outside the expected pulse, across all monitor-bit combinations, both delay modes and several interrupt pulse widths.

// File: rtl/clksup_pkg.sv
package clksup_pkg;

  typedef struct packed {
    logic irq_edge;
    logic long_dly;
    logic force_mon;
    logic mon_en;
  } opt_t;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_STOP = 2'd1,
    SEQ_WAKE = 2'd2
  } seq_st_t;

endpackage

// File: rtl/clksup_sync.sv
module clksup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_d
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q   = chain[STAGES-1];
  assign q_d = chain[STAGES];
endmodule

// File: rtl/clksup_opt_reg.sv
module clksup_opt_reg
  import clksup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output opt_t       opt_q
);
  opt_t wv;
  assign wv = opt_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= '0;
    end else if (wr_en) begin
      opt_q.mon_en    <= wv.mon_en;
      opt_q.force_mon <= opt_q.force_mon | wv.force_mon;
      opt_q.long_dly  <= wv.long_dly;
      opt_q.irq_edge  <= wv.irq_edge;
    end
  end

  assert_force_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    opt_q.force_mon |=> opt_q.force_mon);
endmodule

// File: rtl/clksup_monitor.sv
module clksup_monitor #(
  parameter int MISS_LIMIT = 16,
  parameter int RST_HOLD   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_active,
  input  logic bus_smp,
  output logic fail_rst
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic              s_now, s_old, bus_edge;
  logic [MISS_W-1:0] miss;
  logic [HOLD_W-1:0] hold;

  clksup_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_smp), .q(s_now), .q_d(s_old)
  );

  assign bus_edge = s_now ^ s_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss <= '0;
      hold <= '0;
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
      miss <= '0;
    end else if (!mon_active || bus_edge) begin
      miss <= '0;
    end else if (miss == MISS_W'(MISS_LIMIT - 1)) begin
      hold <= HOLD_W'(RST_HOLD);
      miss <= '0;
    end else begin
      miss <= miss + 1'b1;
    end
  end

  assign fail_rst = (hold != '0);

  assert_quiet_disarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_active && !fail_rst) |=> !fail_rst);
  assert_hold_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_rst) |=> fail_rst);
  assert_edge_rearms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_edge && !fail_rst) |=> !fail_rst);
endmodule

// File: rtl/clksup_stop_seq.sv
module clksup_stop_seq
  import clksup_pkg::*;
#(
  parameter int LONG_DLY  = 4064,
  parameter int SHORT_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake,
  input  logic force_mon,
  input  logic long_dly,
  output logic stop_active,
  output logic resume
);
  localparam int CNT_W = $clog2(LONG_DLY);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SEQ_RUN;
      cnt    <= '0;
      resume <= 1'b0;
    end else begin
      resume <= 1'b0;
      case (st)
        SEQ_RUN: if (stop_req && !force_mon) st <= SEQ_STOP;
        SEQ_STOP: if (wake) begin
          st  <= SEQ_WAKE;
          cnt <= long_dly ? CNT_W'(LONG_DLY - 1) : CNT_W'(SHORT_DLY - 1);
        end
        SEQ_WAKE: if (cnt == '0) begin
          st     <= SEQ_RUN;
          resume <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= SEQ_RUN;
      endcase
    end
  end

  assign stop_active = (st != SEQ_RUN);

  assert_stop_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_mon && !stop_active) |=> !stop_active);
  assert_resume_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  assert_resume_exits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !stop_active);
endmodule

// File: rtl/clksup_irq_sense.sv
module clksup_irq_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic edge_sel,
  input  logic irq_ack,
  output logic irq_req
);
  logic i_now, i_old, fall, latch;

  clksup_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n), .q(i_now), .q_d(i_old)
  );

  assign fall = i_old & ~i_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch <= 1'b0;
    else if (!edge_sel) latch <= 1'b0;
    else if (fall)      latch <= 1'b1;
    else if (irq_ack)   latch <= 1'b0;
  end

  assign irq_req = edge_sel ? latch : ~i_now;

  assert_edge_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && edge_sel && !irq_ack) |=> latch);
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && irq_ack && !fall) |=> !latch);
endmodule

// File: rtl/clksup_top.sv
module clksup_top
  import clksup_pkg::*;
#(
  parameter int MISS_LIMIT = 16,
  parameter int RST_HOLD   = 4,
  parameter int LONG_DLY   = 4064,
  parameter int SHORT_DLY  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] opt_rd,
  input  logic       stop_req,
  input  logic       wake,
  input  logic       bus_clk_smp,
  input  logic       irq_n,
  input  logic       irq_ack,
  output logic       fail_rst,
  output logic       resume,
  output logic       stop_active,
  output logic       irq_req
);
  opt_t opt;
  logic mon_active;

  clksup_opt_reg u_opt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .opt_q(opt)
  );

  assign opt_rd     = opt;
  assign mon_active = opt.force_mon | opt.mon_en;

  clksup_monitor #(.MISS_LIMIT(MISS_LIMIT), .RST_HOLD(RST_HOLD)) u_mon (
    .clk(clk), .rst_n(rst_n), .mon_active(mon_active),
    .bus_smp(bus_clk_smp), .fail_rst(fail_rst)
  );

  clksup_stop_seq #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
    .force_mon(opt.force_mon), .long_dly(opt.long_dly),
    .stop_active(stop_active), .resume(resume)
  );

  clksup_irq_sense u_irq (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .edge_sel(opt.irq_edge),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  assert_stop_needs_noforce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> !$past(opt.force_mon));
endmodule

// File: tb/clksup_top_tb_top.sv
module clksup_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic       stop_req = 1'b0, wake = 1'b0, bus_clk_smp = 1'b0;
  logic       irq_n = 1'b1, irq_ack = 1'b0;
  logic [3:0] opt_rd;
  logic       fail_rst, resume, stop_active, irq_req;
  logic       bus_run = 1'b1;
  int         nvec = 0, nbad = 0, ncyc = 0;

  always #4 clk = ~clk;

  clksup_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .opt_rd(opt_rd),
    .stop_req(stop_req), .wake(wake), .bus_clk_smp(bus_clk_smp), .irq_n(irq_n),
    .irq_ack(irq_ack), .fail_rst(fail_rst), .resume(resume),
    .stop_active(stop_active), .irq_req(irq_req)
  );

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      nbad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", ncyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, ncyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (bus_run) bus_clk_smp = ~bus_clk_smp;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; stop_req = 0; wake = 0; irq_n = 1; irq_ack = 0;
    bus_run = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(logic [3:0] v);
    tick(); wr_en = 1'b1; wr_data = v;
    tick(); wr_en = 1'b0;
  endtask

  task automatic halt_and_watch(string req, logic armed);
    tick(); bus_run = 1'b0;
    for (int i = 1; i <= 24; i++) begin
      tick();
      chk(req, {3'b0, fail_rst}, {3'b0, armed && i >= 19 && i <= 22});
    end
    bus_run = 1'b1;
  endtask

  task automatic stop_wake(int n, int gap);
    tick(); stop_req = 1'b1;
    tick(); stop_req = 1'b0;
    chk("R7 stop entered", {3'b0, stop_active}, 4'h1);
    for (int g = 0; g < gap; g++) begin
      tick();
      chk("R8 parked", {2'b0, stop_active, resume}, 4'h2);
    end
    tick(); wake = 1'b1;
    for (int j = 1; j <= n + 1; j++) begin
      tick();
      if (j == 1) wake = 1'b0;
      chk("R8 resume timing", {3'b0, resume}, {3'b0, j == n + 1});
      chk("R8 stop_active", {3'b0, stop_active}, {3'b0, j <= n});
    end
    tick();
    chk("R8 resume one cycle", {3'b0, resume}, 4'h0);
  endtask

  task automatic irq_pulse(logic edge_md, int w);
    tick(); irq_n = 1'b0;
    for (int j = 1; j <= w + 4; j++) begin
      tick();
      if (j == w) irq_n = 1'b1;
      if (edge_md) chk("R10 edge latch", {3'b0, irq_req}, {3'b0, j >= 3});
      else         chk("R9 level follow", {3'b0, irq_req}, {3'b0, j >= 2 && j <= w + 1});
    end
    if (edge_md) begin
      tick(); irq_ack = 1'b1;
      tick(); irq_ack = 1'b0;
      chk("R10 ack clears", {3'b0, irq_req}, 4'h0);
    end
    for (int k = 0; k < 4; k++) tick();
  endtask

  initial begin
    do_reset();
    chk("R1 opt reset", opt_rd, 4'h0);
    chk("R1 outputs reset", {fail_rst, resume, stop_active, irq_req}, 4'h0);

    for (int v = 0; v < 16; v++) begin
      if (v[1]) continue;
      wr(4'(v));
      chk("R2 write readback", opt_rd, 4'(v));
    end
    wr(4'h0);

    wr(4'h2);
    chk("R3 force set", opt_rd, 4'h2);
    wr(4'h0);
    chk("R3 force sticky", opt_rd, 4'h2);
    tick(); stop_req = 1'b1;
    tick(); stop_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R7 stop ignored when forced", {3'b0, stop_active}, 4'h0);
    end
    do_reset();
    chk("R3 reset clears force", opt_rd, 4'h0);

    for (int c = 0; c < 4; c++) begin
      do_reset();
      wr(4'(c));
      for (int k = 0; k < 30; k++) begin
        tick();
        chk("R6 toggling bus", {3'b0, fail_rst}, 4'h0);
      end
      halt_and_watch(c != 0 ? "R5 failure window" : "R4 disarmed quiet", c != 0);
    end

    do_reset();
    wr(4'h0);
    stop_wake(4, 0);
    stop_wake(4, 3);
    stop_wake(4, 7);
    wr(4'h4);
    stop_wake(4064, 0);
    stop_wake(4064, 5);

    do_reset();
    tick(); stop_req = 1'b1;
    tick(); stop_req = 1'b0; bus_run = 1'b0;
    for (int k = 0; k < 40; k++) begin
      tick();
      chk("R11 stopped unarmed no fail", {3'b0, fail_rst}, 4'h0);
    end
    tick(); wake = 1'b1;
    for (int j = 1; j <= 5; j++) begin
      tick();
      if (j == 1) wake = 1'b0;
      chk("R11 wake completes", {3'b0, resume}, {3'b0, j == 5});
    end
    bus_run = 1'b1;

    do_reset();
    for (int w = 1; w <= 5; w += 2) irq_pulse(1'b0, w);
    wr(4'h8);
    for (int w = 1; w <= 5; w += 2) irq_pulse(1'b1, w);
    tick(); irq_n = 1'b0;
    for (int k = 0; k < 4; k++) tick();
    chk("R10 held low latched", {3'b0, irq_req}, 4'h1);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 held low no reset", {3'b0, irq_req}, 4'h0);
    end
    irq_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule